// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Sequencer

This block sits between a simple register-access port and a 16-bit parallel ATA device bus working in programmed I/O. Each accepted request becomes one timed bus cycle: chip selects and the three device address lines are set, a read or write strobe is pulsed after a programmable setup delay, and a recovery interval follows before the next request is taken. Read data is latched when the read strobe is released. Write data is driven for the whole cycle.

The timing set has three values, all counted in clock periods: setup delay, strobe width and nominal cycle length. It resets to the slowest PIO mode and can be replaced between cycles. Two safety margins are added in hardware. The cycle is lengthened whenever the programmed value would leave less than a fixed recovery floor after the strobe. The chip select is held a fixed number of clocks past the strobe. The host address is decoded into two windows that choose which chip select is driven. The device register number is taken one bit up in the host address, so every register sits at an even host address and byte registers use the low data byte. A device ready input held low while a strobe is active stretches that strobe.

Top module: `pata_pio_seq`

## Requirements
- R1: After reset, req_ready is 1, both chip selects and both strobes are 1 (inactive), ata_dd_oe is 0, req_rvalid is 0, and the timing set is setup RST_SETUP, strobe RST_PULSE, cycle RST_CYCLE (defaults 18, 73, 150 clocks).
- R2: Host address bits [23:21] = 3'b110 select the task window (ata_cs0_n low, ata_cs1_n high). 3'b111 selects the control window (ata_cs1_n low, ata_cs0_n high). Any other value runs a timed cycle that asserts no chip select and no strobe, does not drive the bus and returns no read data.
- R3: ata_da equals req_addr[3:1] for the whole cycle. req_addr[0] has no effect.
- R4: Counting the first clock after acceptance as clock 0, the chip select is active from clock 0. The strobe (ata_dior_n for reads, ata_diow_n for writes, active low) is active from clock S for P clocks, where S is setup and P is strobe width.
- R5: req_ready stays low for Ceff = max(C, S + P + MIN_RECOV) clocks and is then high again. MIN_RECOV defaults to 7.
- R6: The chip select stays active for S + P + CS_HOLD clocks (CS_HOLD defaults to 4), and never beyond the cycle.
- R7: On a write, ata_dd_oe is 1 and ata_dd_out equals the write data on every busy clock. On reads and when idle, ata_dd_oe is 0.
- R8: On a read, req_rdata takes ata_dd_in at the edge that releases ata_dior_n, and req_rvalid is 1 for exactly that one following clock (clock S + P).
- R9: Each clock in which ata_iordy is low while a strobe is active adds one clock to the strobe, to the chip-select time and to the cycle.
- R10: tm_load copies tm_setup, tm_pulse and tm_cycle into the timing set only at an edge where the block is idle and req_valid is low. At any other edge it is ignored.
- R11: Write cycles use exactly the same setup, strobe, chip-select and cycle lengths as read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (24) | Host byte address |
| req_wdata | input | DW (16) | Write data |
| req_ready | output | 1 | Idle; request accepted when valid and ready |
| req_rdata | output | DW (16) | Last captured read data |
| req_rvalid | output | 1 | One-clock pulse when req_rdata updates |
| tm_load | input | 1 | Load new timing set |
| tm_setup | input | TW (8) | Setup clocks |
| tm_pulse | input | TW (8) | Strobe clocks (at least 1) |
| tm_cycle | input | TW (8) | Nominal cycle clocks |
| ata_cs0_n | output | 1 | Task-window chip select, active low |
| ata_cs1_n | output | 1 | Control-window chip select, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_da | output | 3 | Device register address |
| ata_iordy | input | 1 | Device ready; low stretches an active strobe |
| ata_dd_in | input | DW (16) | Data from device |
| ata_dd_out | output | DW (16) | Data to device |
| ata_dd_oe | output | 1 | Drive enable for ata_dd_out |

## Verification
Every output is a register, so results are due at fixed clock offsets from the accepting edge: the chip select and address at offset 0, the strobe from offset S, the read data pulse at offset S + P (plus any ready stalls), and the return of req_ready at offset Ceff. The bench drives and samples only on falling edges. It numbers each falling edge after acceptance and records the offset at which each pin first changes and how long it stays changed. It then compares these counts against values worked out from the timing set, the recovery floor and the hold margin. Ready stalls are placed at known offsets inside the strobe, so the expected extra length is exact.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_TASK = 2'd1,
    WIN_CTRL = 2'd2
  } pio_win_e;

  localparam logic [2:0] TAG_TASK = 3'b110;
  localparam logic [2:0] TAG_CTRL = 3'b111;
endpackage

// File: rtl/pio_win_decode.sv
module pio_win_decode
  import pio_seq_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  output pio_win_e      win,
  output logic [2:0]    da
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[AW-4:4], addr[0]};

  always_comb begin
    unique case (addr[AW-1:AW-3])
      TAG_TASK: win = WIN_TASK;
      TAG_CTRL: win = WIN_CTRL;
      default:  win = WIN_NONE;
    endcase
  end

  // register number sits one bit up: byte lane stays on the low half
  assign da = addr[3:1];
endmodule

// File: rtl/pio_timing_set.sv
module pio_timing_set #(
  parameter int TW        = 8,
  parameter int CW        = TW + 2,
  parameter int RST_SETUP = 18,
  parameter int RST_PULSE = 73,
  parameter int RST_CYCLE = 150,
  parameter int MIN_RECOV = 7,
  parameter int CS_HOLD   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_ok,
  input  logic          load,
  input  logic [TW-1:0] new_setup,
  input  logic [TW-1:0] new_pulse,
  input  logic [TW-1:0] new_cycle,
  output logic [CW-1:0] setup,
  output logic [CW-1:0] active,
  output logic [CW-1:0] cycle_eff,
  output logic [CW-1:0] cs_end
);
  localparam logic [CW-1:0] RECOV_C = CW'(MIN_RECOV);
  localparam logic [CW-1:0] HOLD_C  = CW'(CS_HOLD);

  logic [TW-1:0] s_q, p_q, c_q;
  logic [CW-1:0] floor_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= TW'(RST_SETUP);
      p_q <= TW'(RST_PULSE);
      c_q <= TW'(RST_CYCLE);
    end else if (load && load_ok) begin
      s_q <= new_setup;
      p_q <= new_pulse;
      c_q <= new_cycle;
    end
  end

  always_comb begin
    setup     = CW'(s_q);
    active    = CW'(s_q) + CW'(p_q);
    floor_len = active + RECOV_C;
    cycle_eff = (CW'(c_q) < floor_len) ? floor_len : CW'(c_q);
    cs_end    = active + HOLD_C;
  end

  // R10: timing set frozen while a cycle runs or a request waits
  p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !load_ok |=> ($stable(s_q) && $stable(p_q) && $stable(c_q)));
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  pio_win_e      start_win,
  input  logic [2:0]    start_da,
  input  logic [DW-1:0] start_wd,
  input  logic [CW-1:0] setup,
  input  logic [CW-1:0] active,
  input  logic [CW-1:0] cycle_eff,
  input  logic [CW-1:0] cs_end,
  input  logic          iordy,
  input  logic [DW-1:0] dd_in,
  output logic          busy,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic          dior_n,
  output logic          diow_n,
  output logic [2:0]    da,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          busy_q, busy_n;
  logic [CW-1:0] t_q, t_n;
  logic          we_q, we_n;
  pio_win_e      win_q, win_n;
  logic          pulse_q, pulse_n, hit_n, stall;

  assign hit_n = (win_n != WIN_NONE);
  assign stall = pulse_q && (win_q != WIN_NONE) && !iordy;

  always_comb begin
    busy_n = busy_q;
    t_n    = t_q;
    we_n   = we_q;
    win_n  = win_q;
    if (start) begin
      busy_n = 1'b1;
      t_n    = '0;
      we_n   = start_we;
      win_n  = start_win;
    end else if (busy_q && !stall) begin
      if (t_q == cycle_eff - CW'(1)) busy_n = 1'b0;
      else                            t_n    = t_q + CW'(1);
    end
    pulse_n = busy_n && (t_n >= setup) && (t_n < active);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      t_q     <= '0;
      we_q    <= 1'b0;
      win_q   <= WIN_NONE;
      pulse_q <= 1'b0;
      cs0_n   <= 1'b1;
      cs1_n   <= 1'b1;
      dior_n  <= 1'b1;
      diow_n  <= 1'b1;
      da      <= '0;
      dd_out  <= '0;
      dd_oe   <= 1'b0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      t_q     <= t_n;
      we_q    <= we_n;
      win_q   <= win_n;
      pulse_q <= pulse_n;
      cs0_n   <= !(busy_n && (t_n < cs_end) && (win_n == WIN_TASK));
      cs1_n   <= !(busy_n && (t_n < cs_end) && (win_n == WIN_CTRL));
      dior_n  <= !(pulse_n && hit_n && !we_n);
      diow_n  <= !(pulse_n && hit_n && we_n);
      dd_oe   <= busy_n && hit_n && we_n;
      if (start) begin
        da     <= start_da;
        dd_out <= start_wd;
      end
      // capture on the edge that releases the read strobe
      rvalid <= !dior_n && !(pulse_n && hit_n && !we_n);
      if (!dior_n && !(pulse_n && hit_n && !we_n)) rdata <= dd_in;
    end
  end

  assign busy = busy_q;

  // R4: only one strobe at a time
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));
  // R2: the two windows never overlap
  p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(!cs0_n && !cs1_n));
  // R6: a strobe always sits inside an active chip select
  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n));
  // R1: idle bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cs0_n && cs1_n && dior_n && diow_n && !dd_oe));
  // R8: read data pulse follows the read strobe release
  p_rvalid_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> ($past(!dior_n) && dior_n));
  // R7: the bus is driven only on writes
  p_oe_write_only_r7: assert property (@(posedge clk) disable iff (rst)
    dd_oe |-> dior_n);
  // R9: a stalled strobe stays active
  p_stretch_r9: assert property (@(posedge clk) disable iff (rst)
    ((!dior_n || !diow_n) && !iordy) |=> (!dior_n || !diow_n));
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pio_seq_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int TW        = 8,
  parameter int RST_SETUP = 18,
  parameter int RST_PULSE = 73,
  parameter int RST_CYCLE = 150,
  parameter int MIN_RECOV = 7,
  parameter int CS_HOLD   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  output logic          req_rvalid,
  input  logic          tm_load,
  input  logic [TW-1:0] tm_setup,
  input  logic [TW-1:0] tm_pulse,
  input  logic [TW-1:0] tm_cycle,
  output logic          ata_cs0_n,
  output logic          ata_cs1_n,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [2:0]    ata_da,
  input  logic          ata_iordy,
  input  logic [DW-1:0] ata_dd_in,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe
);
  localparam int CW = TW + 2;

  pio_win_e      dec_win;
  logic [2:0]    dec_da;
  logic          busy, start, load_ok;
  logic [CW-1:0] setup, active, cycle_eff, cs_end;

  assign start     = req_valid && !busy;
  assign load_ok   = !busy && !req_valid;
  assign req_ready = !busy;

  pio_win_decode #(.AW(AW)) u_dec (
    .addr (req_addr),
    .win  (dec_win),
    .da   (dec_da)
  );

  pio_timing_set #(
    .TW(TW), .CW(CW), .RST_SETUP(RST_SETUP), .RST_PULSE(RST_PULSE),
    .RST_CYCLE(RST_CYCLE), .MIN_RECOV(MIN_RECOV), .CS_HOLD(CS_HOLD)
  ) u_tim (
    .clk       (clk),
    .rst       (rst),
    .load_ok   (load_ok),
    .load      (tm_load),
    .new_setup (tm_setup),
    .new_pulse (tm_pulse),
    .new_cycle (tm_cycle),
    .setup     (setup),
    .active    (active),
    .cycle_eff (cycle_eff),
    .cs_end    (cs_end)
  );

  pio_cycle_engine #(.DW(DW), .CW(CW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_we  (req_we),
    .start_win (dec_win),
    .start_da  (dec_da),
    .start_wd  (req_wdata),
    .setup     (setup),
    .active    (active),
    .cycle_eff (cycle_eff),
    .cs_end    (cs_end),
    .iordy     (ata_iordy),
    .dd_in     (ata_dd_in),
    .busy      (busy),
    .cs0_n     (ata_cs0_n),
    .cs1_n     (ata_cs1_n),
    .dior_n    (ata_dior_n),
    .diow_n    (ata_diow_n),
    .da        (ata_da),
    .dd_out    (ata_dd_out),
    .dd_oe     (ata_dd_oe),
    .rdata     (req_rdata),
    .rvalid    (req_rvalid)
  );

  // R5: no new request is taken while a cycle is running
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(ata_da));
endmodule

// File: tb/sim_pata_pio_seq.sv
`timescale 1ns/1ps
module sim_pata_pio_seq;
  localparam int MINR = 7;
  localparam int HOLD = 4;

  typedef struct packed {
    logic [23:0] addr;
    logic        we;
    logic [15:0] wd;
    logic [7:0]  s;
    logic [7:0]  p;
    logic [7:0]  c;
    logic [3:0]  w;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'hC0000E, 1'b0, 16'h0000, 8'd18, 8'd73, 8'd150, 4'd0},
    '{24'hC00000, 1'b1, 16'hA55A, 8'd3,  8'd5,  8'd20,  4'd0},
    '{24'hE0000C, 1'b0, 16'h0000, 8'd2,  8'd4,  8'd6,   4'd0},
    '{24'hE00005, 1'b1, 16'h3C71, 8'd1,  8'd3,  8'd4,   4'd2},
    '{24'hC00007, 1'b0, 16'h0000, 8'd0,  8'd2,  8'd30,  4'd3},
    '{24'h400002, 1'b1, 16'h1234, 8'd2,  8'd3,  8'd10,  4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, req_rvalid;
  logic [15:0] req_rdata;
  logic tm_load = 1'b0;
  logic [7:0] tm_setup = '0, tm_pulse = '0, tm_cycle = '0;
  logic cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [2:0] da;
  logic iordy = 1'b1;
  logic [15:0] dd_in = '0, dd_out;

  int n_chk = 0, n_bad = 0;
  int m_busy, m_cs, m_cs_first, m_cs0, m_cs1, m_str, m_str_first;
  int m_rd, m_wr, m_oe, m_dbad, m_dabad, m_rdv, m_rdv_idx;
  logic [15:0] m_rdata;

  always #2 clk = ~clk;

  pata_pio_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .req_rvalid(req_rvalid), .tm_load(tm_load),
    .tm_setup(tm_setup), .tm_pulse(tm_pulse), .tm_cycle(tm_cycle),
    .ata_cs0_n(cs0_n), .ata_cs1_n(cs1_n), .ata_dior_n(dior_n),
    .ata_diow_n(diow_n), .ata_da(da), .ata_iordy(iordy),
    .ata_dd_in(dd_in), .ata_dd_out(dd_out), .ata_dd_oe(dd_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic load_timing(input int s, input int p, input int c);
    @(negedge clk);
    tm_load = 1'b1; tm_setup = 8'(s); tm_pulse = 8'(p); tm_cycle = 8'(c);
    @(negedge clk);
    tm_load = 1'b0;
  endtask

  // sample k = k-th falling edge after the accepting edge
  task automatic run_access(input logic [23:0] a, input logic we, input logic [15:0] wd,
                            input logic [15:0] din, input int wfrom, input int wlen,
                            input bit with_load);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; dd_in = din;
    if (with_load) begin
      tm_load = 1'b1; tm_setup = 8'd9; tm_pulse = 8'd9; tm_cycle = 8'd40;
    end
    @(negedge clk);
    req_valid = 1'b0; tm_load = 1'b0;
    m_cs = 0; m_cs_first = -1; m_cs0 = 0; m_cs1 = 0; m_str = 0; m_str_first = -1;
    m_rd = 0; m_wr = 0; m_oe = 0; m_dbad = 0; m_dabad = 0; m_rdv = 0; m_rdv_idx = -1;
    m_rdata = '0;
    k = 0;
    while (!req_ready && k < 5000) begin
      if (!cs0_n || !cs1_n) begin
        m_cs++;
        if (m_cs_first < 0) m_cs_first = k;
      end
      if (!cs0_n) m_cs0++;
      if (!cs1_n) m_cs1++;
      if (!dior_n || !diow_n) begin
        m_str++;
        if (m_str_first < 0) m_str_first = k;
      end
      if (!dior_n) m_rd++;
      if (!diow_n) m_wr++;
      if (dd_oe) begin
        m_oe++;
        if (dd_out != wd) m_dbad++;
      end
      if (da != a[3:1]) m_dabad++;
      if (req_rvalid) begin
        m_rdv++; m_rdv_idx = k; m_rdata = req_rdata;
      end
      iordy = !(wlen > 0 && k >= wfrom && k < wfrom + wlen);
      @(negedge clk);
      k++;
    end
    iordy = 1'b1;
    m_busy = k;
  endtask

  task automatic expect_access(input logic [23:0] a, input logic we, input logic [15:0] din,
                               input int s, input int p, input int c, input int w,
                               input string tag);
    bit task_w, ctrl_w, hit;
    int ceff, csl, ww;
    task_w = (a[23:21] == 3'b110);
    ctrl_w = (a[23:21] == 3'b111);
    hit = task_w || ctrl_w;
    ww = hit ? w : 0;
    ceff = ((c < s + p + MINR) ? s + p + MINR : c) + ww;
    csl = hit ? s + p + HOLD + ww : 0;
    if (csl > ceff) csl = ceff;
    chk(m_busy == ceff, {tag, " R5 R11 cycle length"}, m_busy, ceff);
    chk(m_cs == csl, {tag, " R6 R9 chip-select length"}, m_cs, csl);
    chk(m_cs0 == (task_w ? csl : 0), {tag, " R2 cs0 window"}, m_cs0, task_w ? csl : 0);
    chk(m_cs1 == (ctrl_w ? csl : 0), {tag, " R2 cs1 window"}, m_cs1, ctrl_w ? csl : 0);
    chk(m_dabad == 0, {tag, " R3 device address"}, m_dabad, 0);
    if (hit) begin
      chk(m_cs_first == 0, {tag, " R4 cs first clock"}, m_cs_first, 0);
      chk(m_str_first == s, {tag, " R4 strobe start"}, m_str_first, s);
      chk(m_str == p + ww, {tag, " R4 R9 strobe width"}, m_str, p + ww);
      chk(m_rd == (we ? 0 : p + ww), {tag, " R4 read strobe line"}, m_rd, we ? 0 : p + ww);
      chk(m_wr == (we ? p + ww : 0), {tag, " R4 R11 write strobe line"}, m_wr, we ? p + ww : 0);
    end else begin
      chk(m_str == 0, {tag, " R2 no strobe outside windows"}, m_str, 0);
    end
    chk(m_oe == ((we && hit) ? ceff : 0), {tag, " R7 drive span"}, m_oe, (we && hit) ? ceff : 0);
    chk(m_dbad == 0, {tag, " R7 write data"}, m_dbad, 0);
    if (!we && hit) begin
      chk(m_rdv == 1, {tag, " R8 read pulse count"}, m_rdv, 1);
      chk(m_rdv_idx == s + p + ww, {tag, " R8 read pulse clock"}, m_rdv_idx, s + p + ww);
      chk(m_rdata == din, {tag, " R8 read data"}, int'(m_rdata), int'(din));
    end else begin
      chk(m_rdv == 0, {tag, " R8 no read pulse"}, m_rdv, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cs0_n && cs1_n, "R1 chip selects idle", {cs0_n, cs1_n}, 3);
    chk(dior_n && diow_n, "R1 strobes idle", {dior_n, diow_n}, 3);
    chk(!dd_oe && !req_rvalid, "R1 bus released", {dd_oe, req_rvalid}, 0);
    // R1 reset timing set
    run_access(24'hC00002, 1'b0, '0, 16'hBEEF, 0, 0, 1'b0);
    expect_access(24'hC00002, 1'b0, 16'hBEEF, 18, 73, 150, 0, "reset-timing R1");

    for (int i = 0; i < 6; i++) begin
      load_timing(VECS[i].s, VECS[i].p, VECS[i].c);
      run_access(VECS[i].addr, VECS[i].we, VECS[i].wd, ~VECS[i].wd ^ 16'(i),
                 int'(VECS[i].s) + 1, int'(VECS[i].w), 1'b0);
      expect_access(VECS[i].addr, VECS[i].we, ~VECS[i].wd ^ 16'(i), VECS[i].s,
                    VECS[i].p, VECS[i].c, VECS[i].w, $sformatf("vec%0d", i));
    end

    // R10: load during a running cycle is ignored
    load_timing(2, 3, 9);
    fork
      run_access(24'hC00004, 1'b1, 16'h0F0F, '0, 0, 0, 1'b0);
      begin
        repeat (4) @(negedge clk);
        tm_load = 1'b1; tm_setup = 8'd9; tm_pulse = 8'd9; tm_cycle = 8'd40;
        @(negedge clk);
        tm_load = 1'b0;
      end
    join
    expect_access(24'hC00004, 1'b1, '0, 2, 3, 9, 0, "busy-load R10");
    run_access(24'hC00004, 1'b0, '0, 16'h5511, 0, 0, 1'b0);
    expect_access(24'hC00004, 1'b0, 16'h5511, 2, 3, 9, 0, "after-busy-load R10");
    // R10: load alongside a request is ignored
    run_access(24'hE0000C, 1'b0, '0, 16'h7777, 0, 0, 1'b1);
    expect_access(24'hE0000C, 1'b0, 16'h7777, 2, 3, 9, 0, "valid-load R10");
    run_access(24'hE0000C, 1'b1, 16'h6161, '0, 0, 0, 1'b0);
    expect_access(24'hE0000C, 1'b1, '0, 2, 3, 9, 0, "after-valid-load R10 R11");
    // R10: a clean idle load takes effect
    load_timing(9, 9, 40);
    run_access(24'hC0000A, 1'b0, '0, 16'h9A9A, 0, 0, 1'b0);
    expect_access(24'hC0000A, 1'b0, 16'h9A9A, 9, 9, 40, 0, "idle-load R10");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule